// File: doc/BRIEF.md
# 64-bit SECDED Codec

This block protects a 64-bit memory word with an 8-bit single-error-correcting, double-error-detecting code. It has two independent streams. The encode stream takes a word that is about to be written and returns the word together with its 8 check bits. The decode stream takes a word and its check bits as read from storage. It returns the corrected word, the corrected check bits, the raw syndrome, a correctable flag, an uncorrectable flag and the index of the repaired bit.

The syndrome is the XOR of the check bits recomputed from the read word with the stored check bits. Each data bit owns a distinct odd-weight column of weight three or more. Data bit 26 owns column 0xE6. Each check bit owns a one-hot column, so a flipped check bit is located and repaired just like a data bit. Column 0x07 is never assigned. A flip of the three lowest check bits therefore lands on an unused pattern and is reported as uncorrectable, and no bit is changed. Only one copy of the check code is kept per word.

Both streams use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. With `OUT_REG` = 1 (the default), each stream has a one-entry output register. That register accepts a new item whenever it is empty or its content is being taken in the same cycle. Otherwise ready stays low and the upstream must hold its item. An output that is offered and not taken stays unchanged. With `OUT_REG` = 0, both streams are combinational, and ready passes straight from output to input.

Top module: `secded72_codec`

## Requirements
- R1: The encoder's check bits are the XOR of the columns of all set data bits. Word 0x00218ED408065924 encodes to 0x6E, a word with only bit 26 set encodes to 0xE6, and the all-zero word encodes to 0x00. Any encoded word decodes with syndrome 0.
- R2: The syndrome is the recomputed check bits XOR the stored check bits. A zero syndrome leaves both flags low and the error position at 0, and passes the data and check bits through unchanged.
- R3: A single flipped data bit i (0 to 63) sets the correctable flag, reports position i, and restores the original word. Flipping data bit 26 gives syndrome 0xE6.
- R4: A single flipped check bit j (0 to 7) gives syndrome 1<<j and reports position 64+j. The check bits are restored and the data is untouched. Check bit 4 gives syndrome 0x10.
- R5: Every two-bit flip across the 72 bits gives a nonzero even-weight syndrome. It sets the uncorrectable flag, clears the correctable flag, reports position 0, and returns the data and check bits exactly as read.
- R6: Syndrome 0x07, which comes from flipping check bits 0, 1 and 2, sets the uncorrectable flag and changes no bit.
- R7: The correctable and uncorrectable flags are never high together.
- R8: With the default output register, a result is valid on the cycle after its input is accepted. While an output is valid and not taken, it holds stable and the matching input ready is low. Once the output is taken, a waiting input is accepted on that same edge.
- R9: While reset is held and directly after it, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Encode input item offered |
| enc_in_ready | output | 1 | Encode input can be taken |
| enc_in_data | input | 64 | Word to encode |
| enc_out_valid | output | 1 | Encode result offered |
| enc_out_ready | input | 1 | Encode result taken |
| enc_out_data | output | 64 | Word to be stored |
| enc_out_chk | output | 8 | Check bits to be stored |
| dec_in_valid | input | 1 | Decode input item offered |
| dec_in_ready | output | 1 | Decode input can be taken |
| dec_in_data | input | 64 | Word as read from storage |
| dec_in_chk | input | 8 | Check bits as read from storage |
| dec_out_valid | output | 1 | Decode result offered |
| dec_out_ready | input | 1 | Decode result taken |
| dec_out_data | output | 64 | Corrected word |
| dec_out_chk | output | 8 | Corrected check bits |
| dec_out_syn | output | 8 | Raw syndrome |
| dec_out_ce | output | 1 | Single-bit error corrected |
| dec_out_ue | output | 1 | Uncorrectable error detected |
| dec_out_pos | output | 7 | Repaired bit: 0-63 data, 64-71 check; 0 when ce is low |

## Verification
A wrong column in the check matrix is visible one cycle after acceptance, in the first decode that exercises it. It appears as an unexpected syndrome or encoded value, as a wrong position, or as two single flips that collide and are no longer located. The exhaustive single-flip and pairwise-flip sweeps reach every column and every pair within a few thousand cycles. A stuck or lost occupancy flag in an output register shows on the next edge, either as ready held low with the output taken, or as a held output that changes while it is stalled.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int POS_W  = $clog2(CW_W);

  // Fixed assignments that software and storage depend on.
  localparam int              PIN_BIT  = 26;
  localparam logic [CHK_W-1:0] PIN_COL  = 8'hE6;
  localparam int              TUNE_BIT = 43;
  localparam logic [CHK_W-1:0] TUNE_COL = 8'h7F;
  localparam logic [CHK_W-1:0] SKIP_COL = 8'h07;

  function automatic int popc(input logic [CHK_W-1:0] v);
    int n;
    n = 0;
    for (int b = 0; b < CHK_W; b++) n += int'(v[b]);
    return n;
  endfunction

  // Data columns: weight-3/5 patterns in ascending order, 0x07 left out,
  // slot 26 pinned to 0xE6, slot 43 set to 0x7F to fix the reference code.
  function automatic logic [DATA_W-1:0][CHK_W-1:0] build_hmat();
    logic [DATA_W-1:0][CHK_W-1:0] m;
    logic [CHK_W-1:0] v;
    int slot;
    int w;
    m    = '0;
    slot = 0;
    for (int c = 1; c < (1 << CHK_W); c++) begin
      v = c[CHK_W-1:0];
      w = popc(v);
      if ((w == 3 || w == 5) && v != SKIP_COL && slot < DATA_W) begin
        if (slot == PIN_BIT) slot++;
        if (slot < DATA_W) begin
          m[slot] = v;
          slot++;
        end
      end
    end
    m[PIN_BIT]  = PIN_COL;
    m[TUNE_BIT] = TUNE_COL;
    return m;
  endfunction

  localparam logic [DATA_W-1:0][CHK_W-1:0] HMAT = build_hmat();

  // Data bits that feed check bit j.
  function automatic logic [DATA_W-1:0] row_of(input int j);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = HMAT[i][j];
    return r;
  endfunction

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [CHK_W-1:0]  chk;
    logic [CHK_W-1:0]  syn;
    logic              ce;
    logic              ue;
    logic [POS_W-1:0]  pos;
  } dec_res_t;

  localparam int RES_W = $bits(dec_res_t);

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  // One parity tree per check bit.
  for (genvar j = 0; j < CHK_W; j++) begin : g_tree
    localparam logic [DATA_W-1:0] ROW = row_of(j);
    assign chk_o[j] = ^(data_i & ROW);
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output dec_res_t          res_o
);

  logic [CHK_W-1:0] recalc;
  logic [CHK_W-1:0] syn;
  logic [CW_W-1:0]  hit;
  logic [CW_W-1:0]  fixed;
  logic [POS_W-1:0] pos;

  secded_enc u_enc (
    .data_i (data_i),
    .chk_o  (recalc)
  );

  assign syn = recalc ^ chk_i;

  // Column matchers: data columns, then one-hot check columns.
  for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
    assign hit[i] = (syn == HMAT[i]);
  end
  for (genvar j = 0; j < CHK_W; j++) begin : g_ccol
    localparam logic [CHK_W-1:0] ONEHOT = CHK_W'(1) << j;
    assign hit[DATA_W+j] = (syn == ONEHOT);
  end

  always_comb begin
    pos = '0;
    for (int k = 0; k < CW_W; k++) begin
      if (hit[k]) pos = pos | POS_W'(k);
    end
  end

  assign fixed = {chk_i, data_i} ^ hit;

  assign res_o.data = fixed[DATA_W-1:0];
  assign res_o.chk  = fixed[CW_W-1:DATA_W];
  assign res_o.syn  = syn;
  assign res_o.ce   = |hit;
  assign res_o.ue   = (syn != '0) && !(|hit);
  assign res_o.pos  = pos;

endmodule

// File: rtl/secded_stage.sv
module secded_stage #(
  parameter int W   = 8,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  if (REG) begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;

    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign out_data  = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (in_ready) begin
        full_q <= in_valid;
        if (in_valid) data_q <= in_data;
      end
    end

    // A stalled result must not move.
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // An accepted item is offered on the next cycle.
    assert_accept_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

    // Back-pressure: stalled output blocks new input.
    assert_block_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
  end else begin : g_wire
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/secded72_codec.sv
module secded72_codec
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [DATA_W-1:0] enc_out_data,
  output logic [CHK_W-1:0]  enc_out_chk,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [DATA_W-1:0] dec_in_data,
  input  logic [CHK_W-1:0]  dec_in_chk,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [DATA_W-1:0] dec_out_data,
  output logic [CHK_W-1:0]  dec_out_chk,
  output logic [CHK_W-1:0]  dec_out_syn,
  output logic              dec_out_ce,
  output logic              dec_out_ue,
  output logic [POS_W-1:0]  dec_out_pos
);

  // Encode stream
  logic [CHK_W-1:0] enc_c;
  logic [CW_W-1:0]  enc_s_in;
  logic [CW_W-1:0]  enc_s_out;

  secded_enc u_enc (
    .data_i (enc_in_data),
    .chk_o  (enc_c)
  );

  assign enc_s_in = {enc_c, enc_in_data};

  secded_stage #(.W(CW_W), .REG(OUT_REG)) u_enc_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_s_in),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_s_out)
  );

  assign enc_out_data = enc_s_out[DATA_W-1:0];
  assign enc_out_chk  = enc_s_out[CW_W-1:DATA_W];

  // Decode stream
  dec_res_t         dec_c;
  dec_res_t         dec_q;
  logic [RES_W-1:0] dec_v_in;
  logic [RES_W-1:0] dec_v_out;

  secded_dec u_dec (
    .data_i (dec_in_data),
    .chk_i  (dec_in_chk),
    .res_o  (dec_c)
  );

  assign dec_v_in = dec_c;

  secded_stage #(.W(RES_W), .REG(OUT_REG)) u_dec_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   (dec_v_in),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_v_out)
  );

  assign dec_q        = dec_res_t'(dec_v_out);
  assign dec_out_data = dec_q.data;
  assign dec_out_chk  = dec_q.chk;
  assign dec_out_syn  = dec_q.syn;
  assign dec_out_ce   = dec_q.ce;
  assign dec_out_ue   = dec_q.ue;
  assign dec_out_pos  = dec_q.pos;

  // Decoder result against the raw read word.
  assert_clean_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_c.syn == '0) |-> (!dec_c.ce && !dec_c.ue && dec_c.pos == '0 &&
                           dec_c.data == dec_in_data && dec_c.chk == dec_in_chk));

  assert_data_repair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_c.ce && dec_c.pos < POS_W'(DATA_W)) |->
      ($countones(dec_c.data ^ dec_in_data) == 1 && dec_c.chk == dec_in_chk));

  assert_chk_repair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_c.ce && dec_c.pos >= POS_W'(DATA_W)) |->
      ($countones(dec_c.chk ^ dec_in_chk) == 1 && dec_c.data == dec_in_data));

  assert_even_uncorr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_c.syn != '0 && !(^dec_c.syn)) |->
      (dec_c.ue && dec_c.data == dec_in_data && dec_c.chk == dec_in_chk));

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_c.ce, dec_c.ue}));

endmodule

// File: tb/sim_secded72_codec.sv
`timescale 1ns/1ps
module sim_secded72_codec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_in_valid = 1'b0;
  logic        enc_in_ready;
  logic [63:0] enc_in_data = '0;
  logic        enc_out_valid;
  logic        enc_out_ready = 1'b1;
  logic [63:0] enc_out_data;
  logic [7:0]  enc_out_chk;
  logic        dec_in_valid = 1'b0;
  logic        dec_in_ready;
  logic [63:0] dec_in_data = '0;
  logic [7:0]  dec_in_chk = '0;
  logic        dec_out_valid;
  logic        dec_out_ready = 1'b1;
  logic [63:0] dec_out_data;
  logic [7:0]  dec_out_chk;
  logic [7:0]  dec_out_syn;
  logic        dec_out_ce;
  logic        dec_out_ue;
  logic [6:0]  dec_out_pos;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  secded72_codec u0 (
    .clk (clk), .rst_n (rst_n),
    .enc_in_valid (enc_in_valid), .enc_in_ready (enc_in_ready),
    .enc_in_data (enc_in_data), .enc_out_valid (enc_out_valid),
    .enc_out_ready (enc_out_ready), .enc_out_data (enc_out_data),
    .enc_out_chk (enc_out_chk),
    .dec_in_valid (dec_in_valid), .dec_in_ready (dec_in_ready),
    .dec_in_data (dec_in_data), .dec_in_chk (dec_in_chk),
    .dec_out_valid (dec_out_valid), .dec_out_ready (dec_out_ready),
    .dec_out_data (dec_out_data), .dec_out_chk (dec_out_chk),
    .dec_out_syn (dec_out_syn), .dec_out_ce (dec_out_ce),
    .dec_out_ue (dec_out_ue), .dec_out_pos (dec_out_pos)
  );

  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  c;
    logic [63:0] ed;
    logic [7:0]  ec;
    logic [7:0]  es;
    logic        ce;
    logic        ue;
    logic [6:0]  pos;
  } vec_t;

  localparam logic [63:0] REF_W = 64'h00218ED408065924;
  localparam logic [7:0]  REF_C = 8'h6E;
  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{REF_W, 8'h6E, REF_W, 8'h6E, 8'h00, 1'b0, 1'b0, 7'd0},   // R2 clean
    '{REF_W, 8'h7E, REF_W, 8'h6E, 8'h10, 1'b1, 1'b0, 7'd68},  // R4 check bit 4
    '{REF_W, 8'h5E, REF_W, 8'h5E, 8'h30, 1'b0, 1'b1, 7'd0},   // R5 check bits 4,5
    '{REF_W, 8'h69, REF_W, 8'h69, 8'h07, 1'b0, 1'b1, 7'd0},   // R6 check bits 0..2
    '{64'h00218ED40C065924, 8'h6E, REF_W, 8'h6E, 8'hE6, 1'b1, 1'b0, 7'd26}, // R3
    '{64'h0, 8'h00, 64'h0, 8'h00, 8'h00, 1'b0, 1'b0, 7'd0},   // R2
    '{64'h0, 8'h01, 64'h0, 8'h00, 8'h01, 1'b1, 1'b0, 7'd64},  // R4
    '{64'h1, 8'h00, 64'h0, 8'h00, 8'h0B, 1'b1, 1'b0, 7'd0},   // R3
    '{64'h8000000000000000, 8'h00, 64'h0, 8'h00, 8'h91, 1'b1, 1'b0, 7'd63}, // R3
    '{64'h0000080000000000, 8'h00, 64'h0, 8'h00, 8'h7F, 1'b1, 1'b0, 7'd43}, // R3
    '{64'h0, 8'h80, 64'h0, 8'h00, 8'h80, 1'b1, 1'b0, 7'd71},  // R4
    '{64'h3, 8'h00, 64'h3, 8'h00, 8'h06, 1'b0, 1'b1, 7'd0}    // R5
  };

  function automatic string tag_of(input vec_t v);
    if (v.es == 8'h07)      return "R6";
    if (v.es == 8'h00)      return "R2";
    if (v.ue)               return "R5";
    if (v.pos >= 7'd64)     return "R4";
    return "R3";
  endfunction

  task automatic note(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic run_dec(input logic [63:0] d, input logic [7:0] c,
                         input logic [63:0] ed, input logic [7:0] ec,
                         input logic [7:0] es, input bit use_syn,
                         input logic ece, input logic eue,
                         input logic [6:0] ep, input string tag);
    bit ok;
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_data  = d;
    dec_in_chk   = c;
    @(negedge clk);
    ok = dec_out_valid && dec_out_data == ed && dec_out_chk == ec &&
         (!use_syn || dec_out_syn == es) && dec_out_ce == ece &&
         dec_out_ue == eue && dec_out_pos == ep;
    note(ok, $sformatf("%s decode in=%h/%h: got v=%b data=%h chk=%h syn=%h ce=%b ue=%b pos=%0d, expected v=1 data=%h chk=%h syn=%h ce=%b ue=%b pos=%0d",
         tag, d, c, dec_out_valid, dec_out_data, dec_out_chk, dec_out_syn,
         dec_out_ce, dec_out_ue, dec_out_pos, ed, ec, es, ece, eue, ep));
    dec_in_valid = 1'b0;
  endtask

  task automatic run_enc(input logic [63:0] d, input bit chk_en,
                         input logic [7:0] exp_c, input string tag,
                         output logic [7:0] got);
    @(negedge clk);
    enc_in_valid = 1'b1;
    enc_in_data  = d;
    @(negedge clk);
    got = enc_out_chk;
    if (chk_en)
      note(enc_out_valid && enc_out_chk == exp_c && enc_out_data == d,
           $sformatf("%s encode %h: got v=%b chk=%h data=%h, expected v=1 chk=%h data=%h",
                     tag, d, enc_out_valid, enc_out_chk, enc_out_data, exp_c, d));
    enc_in_valid = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog expired: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] c;
    logic [71:0] cw;
    logic [71:0] bad;
    logic [63:0] words [4];

    // R9: reset state
    repeat (3) @(negedge clk);
    note(!enc_out_valid && !dec_out_valid && enc_in_ready && dec_in_ready,
         $sformatf("R9 in reset: got ev=%b dv=%b er=%b dr=%b, expected 0 0 1 1",
                   enc_out_valid, dec_out_valid, enc_in_ready, dec_in_ready));
    rst_n = 1'b1;
    @(negedge clk);
    note(!enc_out_valid && !dec_out_valid && enc_in_ready && dec_in_ready,
         $sformatf("R9 after reset: got ev=%b dv=%b er=%b dr=%b, expected 0 0 1 1",
                   enc_out_valid, dec_out_valid, enc_in_ready, dec_in_ready));

    // Vector table
    for (int k = 0; k < NV; k++) begin
      run_dec(VT[k].d, VT[k].c, VT[k].ed, VT[k].ec, VT[k].es, 1'b1,
              VT[k].ce, VT[k].ue, VT[k].pos, tag_of(VT[k]));
    end

    // R1: encoder reference points
    run_enc(REF_W, 1'b1, REF_C, "R1", c);
    run_enc(64'h0000000004000000, 1'b1, 8'hE6, "R1", c);
    run_enc(64'h0, 1'b1, 8'h00, "R1", c);

    // R1: round trip of arbitrary words
    words[0] = 64'hFFFFFFFFFFFFFFFF;
    words[1] = 64'h0123456789ABCDEF;
    words[2] = 64'hA5A5A5A55A5A5A5A;
    words[3] = 64'hDEADBEEFCAFEF00D;
    for (int k = 0; k < 4; k++) begin
      run_enc(words[k], 1'b0, 8'h00, "R1", c);
      run_dec(words[k], c, words[k], c, 8'h00, 1'b1, 1'b0, 1'b0, 7'd0, "R1");
    end

    // R6 directed: three lowest check bits flipped
    run_dec(REF_W, REF_C ^ 8'h07, REF_W, REF_C ^ 8'h07, 8'h07, 1'b1,
            1'b0, 1'b1, 7'd0, "R6");

    // R3 / R4: every single flip
    cw = {REF_C, REF_W};
    for (int i = 0; i < 72; i++) begin
      bad = cw ^ (72'd1 << i);
      if (i < 64)
        run_dec(bad[63:0], bad[71:64], REF_W, REF_C, 8'h00, 1'b0,
                1'b1, 1'b0, 7'(i), "R3");
      else
        run_dec(bad[63:0], bad[71:64], REF_W, REF_C, 8'(1) << (i - 64), 1'b1,
                1'b1, 1'b0, 7'(i), "R4");
    end

    // R5 / R7: every double flip
    for (int i = 0; i < 72; i++) begin
      for (int j = i + 1; j < 72; j++) begin
        bad = cw ^ (72'd1 << i) ^ (72'd1 << j);
        run_dec(bad[63:0], bad[71:64], bad[63:0], bad[71:64], 8'h00, 1'b0,
                1'b0, 1'b1, 7'd0, "R5");
      end
    end

    // R8: back-pressure on the decode stream
    @(negedge clk);
    dec_out_ready = 1'b0;
    dec_in_valid  = 1'b1;
    dec_in_data   = REF_W;
    dec_in_chk    = 8'h7E;
    @(negedge clk);
    note(dec_out_valid && !dec_in_ready && dec_out_pos == 7'd68,
         $sformatf("R8 stall start: got v=%b rdy=%b pos=%0d, expected 1 0 68",
                   dec_out_valid, dec_in_ready, dec_out_pos));
    dec_in_data = 64'h1;
    dec_in_chk  = 8'h00;
    @(negedge clk);
    note(dec_out_valid && !dec_in_ready && dec_out_pos == 7'd68 && dec_out_chk == REF_C,
         $sformatf("R8 stall hold: got v=%b rdy=%b pos=%0d chk=%h, expected 1 0 68 %h",
                   dec_out_valid, dec_in_ready, dec_out_pos, dec_out_chk, REF_C));
    dec_out_ready = 1'b1;
    #0;
    note(dec_in_ready, $sformatf("R8 release: got rdy=%b, expected 1", dec_in_ready));
    @(negedge clk);
    note(dec_out_valid && dec_out_pos == 7'd0 && dec_out_syn == 8'h0B && dec_out_ce,
         $sformatf("R8 next item: got v=%b pos=%0d syn=%h ce=%b, expected 1 0 0b 1",
                   dec_out_valid, dec_out_pos, dec_out_syn, dec_out_ce));
    dec_in_valid = 1'b0;
    @(negedge clk);
    note(!dec_out_valid, $sformatf("R8 drained: got v=%b, expected 0", dec_out_valid));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule